// File: doc/BRIEF.md
# Block Address Translator

This block maps a 32-bit effective address onto a physical address through four programmable block entries. Each entry covers one aligned block whose size is a power of two between 128 KB and 256 MB. The size comes from a thermometer mask that widens the address compare and passes the matching low effective-address bits through to the physical address. Each entry also carries cache attributes and an access-protection code. Validity is qualified separately for supervisor and user accesses.

A lookup presents an address, a privilege flag and a read/write flag. One clock later the block returns a hit flag, the physical address, the four attribute bits and a protection-violation flag. The entries are loaded through a simple write port. Each write targets either the upper word (match side) or the lower word (translation side) of one entry.

Top module: `bat_xlate`

## Requirements
- R1: While reset is low, and in the first cycle after it, all outputs are 0 and no entry is valid.
- R2: An entry matches when effective-address bits [31:17] equal its effective block index, ignoring every position where its length mask holds a 1; the mask is a thermometer code (0x000 = 128 KB, 0x7FF = 256 MB).
- R3: An entry takes part only if its supervisor-valid bit is set (for a supervisor lookup) or its user-valid bit is set (for a user lookup).
- R4: On a hit, physical bits [31:28] are the physical block index bits [14:11], bits [27:17] are the physical index bits [10:0] ORed with the effective-address bits selected by the mask, and bits [16:0] equal effective-address bits [16:0].
- R5: On a hit, `attr_o` is {write-through, cache-inhibit, coherent, guarded} taken from the winning entry.
- R6: When several entries match, the lowest-numbered entry decides every output.
- R7: Protection code 0 flags a violation on any access, code 1 flags a violation on writes, code 2 never does; a violating access still reports a hit.
- R8: Protection code 3 behaves as read only.
- R9: On a miss, `hit_o`, `pa_o`, `attr_o` and `viol_o` are all 0.
- R10: Results appear on the outputs one clock after the lookup inputs are sampled; a register write becomes visible to lookups sampled at the following edge, not the same edge.
- R11: Upper word layout: [31:17] effective index, [12:2] length mask, [1] supervisor-valid, [0] user-valid. Lower word layout: [31:17] physical index, [6] write-through, [5] cache-inhibit, [4] coherent, [3] guarded, [1:0] protection code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_entry | input | 2 | Entry number to write |
| cfg_upper | input | 1 | 1 selects the upper word, 0 the lower word |
| cfg_wdata | input | 32 | Write data (layout per R11) |
| ea_i | input | 32 | Effective address of the lookup |
| sup_i | input | 1 | 1 = supervisor access, 0 = user access |
| wr_i | input | 1 | 1 = write access, 0 = read access |
| hit_o | output | 1 | Registered hit flag |
| pa_o | output | 32 | Registered physical address |
| attr_o | output | 4 | {write-through, cache-inhibit, coherent, guarded} |
| viol_o | output | 1 | Registered protection violation |

## Verification
On every cycle, the assertions check four things. A violation is only ever reported together with a hit. A miss leaves the address and attributes at zero. The block offset of a hit passes through unchanged. At most one entry is granted. The bench scenarios show what the assertions cannot: privilege gating, masked matching across block sizes, the OR-composition of the physical address, priority among overlapping entries, the protection code table and the write-versus-lookup timing. For these it compares each cycle against an address-range model.

// File: rtl/bat_pkg.sv
// Shared parameters, entry types and word decoders for the block translator.
// Assumes a 32-bit address, with block bits starting at bit 17.
package bat_pkg;
    parameter int unsigned ADDR_W  = 32;
    parameter int unsigned BLK_LSB = 17;
    parameter int unsigned MASK_W  = 11;
    parameter int unsigned ENTRIES = 4;
    parameter int unsigned ATTR_W  = 4;

    localparam int unsigned IDX_W = ADDR_W - BLK_LSB;
    localparam int unsigned FIX_W = IDX_W - MASK_W;
    localparam int unsigned SEL_W = $clog2(ENTRIES);

    typedef enum logic [1:0] {
        PROT_NONE = 2'd0,
        PROT_RO   = 2'd1,
        PROT_RW   = 2'd2,
        PROT_RO2  = 2'd3
    } prot_e;

    typedef struct packed {
        logic [IDX_W-1:0]  eff_idx;
        logic [MASK_W-1:0] len_mask;
        logic              sup_ok;
        logic              usr_ok;
    } upper_t;

    typedef struct packed {
        logic [IDX_W-1:0]  phys_idx;
        logic [ATTR_W-1:0] attr;
        prot_e             prot;
    } lower_t;

    // Unpack an upper word into the match-side fields.
    function automatic upper_t decode_upper(input logic [ADDR_W-1:0] w);
        upper_t u;
        u.eff_idx  = w[ADDR_W-1:BLK_LSB];
        u.len_mask = w[MASK_W+1:2];
        u.sup_ok   = w[1];
        u.usr_ok   = w[0];
        return u;
    endfunction

    // Unpack a lower word into the translation-side fields.
    function automatic lower_t decode_lower(input logic [ADDR_W-1:0] w);
        lower_t l;
        l.phys_idx = w[ADDR_W-1:BLK_LSB];
        l.attr     = w[ATTR_W+2:3];
        l.prot     = prot_e'(w[1:0]);
        return l;
    endfunction
endpackage

// File: rtl/bat_regs.sv
// Entry storage: one upper and one lower register per entry.
// Assumes writes are single-cycle strobes. Reset clears every word,
// so no entry is valid after reset.
module bat_regs
    import bat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SEL_W-1:0]  entry,
    input  logic              upper_sel,
    input  logic [ADDR_W-1:0] wdata,
    output upper_t            up_q [ENTRIES],
    output lower_t            lo_q [ENTRIES]
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        // Load the selected word of this entry; clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                up_q[g] <= '0;
                lo_q[g] <= '0;
            end else if (we && entry == SEL_W'(g)) begin
                if (upper_sel) up_q[g] <= decode_upper(wdata);
                else           lo_q[g] <= decode_lower(wdata);
            end
        end
    end
endmodule

// File: rtl/bat_match.sv
// Per-entry masked comparator with privilege qualification.
// Assumes the length mask is a thermometer code aligned to the low index bits.
module bat_match
    import bat_pkg::*;
(
    input  logic [ADDR_W-1:0]  ea,
    input  logic               sup,
    input  upper_t             up [ENTRIES],
    output logic [ENTRIES-1:0] hit_vec
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        logic [IDX_W-1:0] care;
        logic             usable;
        // Compare only index bits not covered by the length mask.
        always_comb begin
            care       = ~{{FIX_W{1'b0}}, up[g].len_mask};
            usable     = sup ? up[g].sup_ok : up[g].usr_ok;
            hit_vec[g] = usable &&
                         (((ea[ADDR_W-1:BLK_LSB] ^ up[g].eff_idx) & care) == '0);
        end
    end
endmodule

// File: rtl/bat_select.sv
// Priority pick among matching entries, physical address composition
// and protection check. Purely combinational; the lowest index wins.
module bat_select
    import bat_pkg::*;
(
    input  logic [ENTRIES-1:0] hit_vec,
    input  upper_t             up [ENTRIES],
    input  lower_t             lo [ENTRIES],
    input  logic [ADDR_W-1:0]  ea,
    input  logic               is_wr,
    output logic [ENTRIES-1:0] grant,
    output logic               any_hit,
    output logic [ADDR_W-1:0]  pa,
    output logic [ATTR_W-1:0]  attr,
    output logic               viol
);
    logic [SEL_W-1:0] win;

    // Scan from the top down so the lowest matching entry is left standing.
    always_comb begin
        win   = '0;
        grant = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                win   = SEL_W'(i);
                grant = ENTRIES'(1) << i;
            end
        end
        any_hit = |hit_vec;
    end

    // Build the physical address and protection result from the winner.
    always_comb begin
        pa   = '0;
        attr = '0;
        viol = 1'b0;
        if (any_hit) begin
            pa[ADDR_W-1:ADDR_W-FIX_W] = lo[win].phys_idx[IDX_W-1:MASK_W];
            pa[BLK_LSB+MASK_W-1:BLK_LSB] = lo[win].phys_idx[MASK_W-1:0] |
                (ea[BLK_LSB+MASK_W-1:BLK_LSB] & up[win].len_mask);
            pa[BLK_LSB-1:0] = ea[BLK_LSB-1:0];
            attr = lo[win].attr;
            unique case (lo[win].prot)
                PROT_NONE: viol = 1'b1;
                PROT_RW:   viol = 1'b0;
                default:   viol = is_wr;
            endcase
        end
    end
endmodule

// File: rtl/bat_xlate.sv
// Top of the block translator: entry registers, comparators, selector
// and one output register stage. Lookups return one clock after sampling.
module bat_xlate
    import bat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_entry,
    input  logic              cfg_upper,
    input  logic [31:0]       cfg_wdata,
    input  logic [31:0]       ea_i,
    input  logic              sup_i,
    input  logic              wr_i,
    output logic              hit_o,
    output logic [31:0]       pa_o,
    output logic [3:0]        attr_o,
    output logic              viol_o
);
    upper_t             up_q [ENTRIES];
    lower_t             lo_q [ENTRIES];
    logic [ENTRIES-1:0] hit_vec;
    logic [ENTRIES-1:0] grant;
    logic               any_hit;
    logic [ADDR_W-1:0]  pa_c;
    logic [ATTR_W-1:0]  attr_c;
    logic               viol_c;

    bat_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .entry     (cfg_entry),
        .upper_sel (cfg_upper),
        .wdata     (cfg_wdata),
        .up_q      (up_q),
        .lo_q      (lo_q)
    );

    bat_match u_match (
        .ea      (ea_i),
        .sup     (sup_i),
        .up      (up_q),
        .hit_vec (hit_vec)
    );

    bat_select u_sel (
        .hit_vec (hit_vec),
        .up      (up_q),
        .lo      (lo_q),
        .ea      (ea_i),
        .is_wr   (wr_i),
        .grant   (grant),
        .any_hit (any_hit),
        .pa      (pa_c),
        .attr    (attr_c),
        .viol    (viol_c)
    );

    // Register the lookup result; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_o  <= 1'b0;
            pa_o   <= '0;
            attr_o <= '0;
            viol_o <= 1'b0;
        end else begin
            hit_o  <= any_hit;
            pa_o   <= pa_c;
            attr_o <= attr_c;
            viol_o <= viol_c;
        end
    end

    AST_VIOL_WITH_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        viol_o |-> hit_o); // R7
    AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_o |-> (pa_o == '0 && attr_o == '0)); // R9
    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> pa_o[BLK_LSB-1:0] == $past(ea_i[BLK_LSB-1:0])); // R4
    AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && (any_hit == (grant != '0))); // R6
endmodule

// File: tb/bat_xlate_test.sv
module bat_xlate_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        cfg_we = 0;
    logic [1:0]  cfg_entry = 0;
    logic        cfg_upper = 0;
    logic [31:0] cfg_wdata = 0;
    logic [31:0] ea_i = 0;
    logic        sup_i = 0;
    logic        wr_i = 0;
    logic        hit_o, viol_o;
    logic [31:0] pa_o;
    logic [3:0]  attr_o;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    logic [31:0] m_up [4];
    logic [31:0] m_lo [4];
    logic        e_hit, e_viol;
    logic [31:0] e_pa;
    logic [3:0]  e_attr;

    always #5 clk = ~clk;

    bat_xlate uut (.*);

    // Behavioural model: address-range test over the block size.
    task automatic model_eval();
        e_hit = 0; e_viol = 0; e_pa = 0; e_attr = 0;
        for (int i = 0; i < 4; i++) begin
            longint size, base;
            bit ok;
            ok   = sup_i ? m_up[i][1] : m_up[i][0];
            size = 64'd1 << (17 + $countones(m_up[i][12:2]));
            base = longint'(m_up[i][31:17]) * 131072;
            base = base - (base % size);
            if (!e_hit && ok && longint'(ea_i) >= base && longint'(ea_i) < base + size) begin
                e_hit  = 1;
                e_pa   = 32'((longint'(m_lo[i][31:17]) * 131072) | (longint'(ea_i) % size));
                e_attr = m_lo[i][6:3];
                case (m_lo[i][1:0])
                    2'd0: e_viol = 1;
                    2'd2: e_viol = 0;
                    default: e_viol = wr_i;
                endcase
            end
        end
    endtask

    task automatic compare(input string tag);
        n_run++;
        if (hit_o !== e_hit || pa_o !== e_pa || attr_o !== e_attr || viol_o !== e_viol) begin
            n_fail++;
            $display("FAIL %s: got hit=%0b pa=%h attr=%h viol=%0b exp hit=%0b pa=%h attr=%h viol=%0b",
                     tag, hit_o, pa_o, attr_o, viol_o, e_hit, e_pa, e_attr, e_viol);
        end
    endtask

    // One clock: drive at negedge, model at posedge, compare at next negedge.
    task automatic step(input logic [31:0] ea, input logic sup, input logic wr,
                        input logic we, input logic [1:0] ent, input logic upr,
                        input logic [31:0] wd, input string tag);
        ea_i = ea; sup_i = sup; wr_i = wr;
        cfg_we = we; cfg_entry = ent; cfg_upper = upr; cfg_wdata = wd;
        @(posedge clk);
        model_eval();
        if (we) begin
            if (upr) m_up[ent] = wd; else m_lo[ent] = wd;
        end
        @(negedge clk);
        compare(tag);
    endtask

    task automatic look(input logic [31:0] ea, input logic sup, input logic wr, input string tag);
        step(ea, sup, wr, 0, 0, 0, 0, tag);
    endtask

    task automatic wr_word(input logic [1:0] ent, input logic upr, input logic [31:0] wd);
        step(0, 1, 0, 1, ent, upr, wd, "R11 write");
    endtask

    function automatic logic [31:0] mk_up(input logic [14:0] idx, input logic [10:0] m,
                                          input logic s, input logic u);
        return {idx, 4'b0, m, s, u};
    endfunction

    function automatic logic [31:0] mk_lo(input logic [14:0] idx, input logic [3:0] a,
                                          input logic [1:0] p);
        return {idx, 10'b0, a, 1'b0, p};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) begin m_up[i] = 0; m_lo[i] = 0; end
        e_hit = 0; e_viol = 0; e_pa = 0; e_attr = 0;
        repeat (3) @(negedge clk);
        compare("R1 in reset");
        rst_n = 1;
        look(32'h0020_0000, 1, 0, "R1 first cycle after reset");
        look(32'hFFFF_FFFF, 0, 1, "R9 nothing valid");
        // Entry 0: 128 KB at 0x0020_0000, supervisor only, RW, cache-inhibit+guarded.
        wr_word(0, 1, mk_up(15'h0010, 11'h000, 1, 0));
        wr_word(0, 0, mk_lo(15'h0100, 4'b0101, 2'd2));
        look(32'h0020_1234, 1, 1, "R2 R4 R5 supervisor hit");
        look(32'h0020_1234, 0, 0, "R3 user blocked");
        look(32'h0022_0000, 1, 0, "R2 past block end");
        look(32'h0021_FFFF, 1, 0, "R2 last byte of block");
        // Entry 1: 1 MB at 0x1000_0000, both privileges, read only, phys idx low bit set.
        wr_word(1, 1, mk_up(15'h0800, 11'h007, 1, 1));
        wr_word(1, 0, mk_lo(15'h2001, 4'b1000, 2'd1));
        look(32'h100A_BCDE, 0, 0, "R4 OR composition user read");
        look(32'h100A_BCDE, 0, 1, "R7 write to read only");
        look(32'h1010_0000, 1, 0, "R2 outside 1MB");
        // Entry 2 overlaps entry 1 with RW; entry 1 must still win.
        wr_word(2, 1, mk_up(15'h0800, 11'h00F, 1, 1));
        wr_word(2, 0, mk_lo(15'h3000, 4'b0010, 2'd2));
        look(32'h1000_0010, 1, 1, "R6 lowest entry wins");
        look(32'h1018_0000, 1, 1, "R6 only entry 2 covers");
        // Entry 3: 256 MB at 0xF000_0000, protection code 3.
        wr_word(3, 1, mk_up(15'h7800, 11'h7FF, 1, 1));
        wr_word(3, 0, mk_lo(15'h0000, 4'b1111, 2'd3));
        look(32'hFEDC_BA98, 1, 0, "R8 code 3 read");
        look(32'hFEDC_BA98, 0, 1, "R8 code 3 write");
        // Entry 0 to no access; the lookup in the same cycle still sees RW.
        step(32'h0020_0040, 1, 0, 1, 0, 0, mk_lo(15'h0100, 4'b0000, 2'd0), "R10 same-edge write");
        look(32'h0020_0040, 1, 0, "R7 R10 no access read");
        look(32'h0020_0040, 1, 1, "R7 no access write");
        // Mixed sweep across every region and around it.
        for (int k = 0; k < 400; k++) begin
            logic [31:0] a;
            a = $urandom;
            case (k % 5)
                0: a = 32'h0020_0000 | (a & 32'h0003_FFFF);
                1: a = 32'h1000_0000 | (a & 32'h001F_FFFF);
                2: a = 32'hF000_0000 | (a & 32'h0FFF_FFFF);
                default: ;
            endcase
            look(a, 1'($urandom), 1'($urandom), "R2 R3 R4 R6 R7 sweep");
        end
        rst_n = 0;
        for (int i = 0; i < 4; i++) begin m_up[i] = 0; m_lo[i] = 0; end
        @(posedge clk); @(negedge clk);
        e_hit = 0; e_viol = 0; e_pa = 0; e_attr = 0;
        compare("R1 reset clears outputs");
        rst_n = 1;
        look(32'hFEDC_BA98, 1, 0, "R1 entries cleared");
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule